// File: doc/BRIEF.md
# Low-Power Mode Controller with Oscillator Settling Timer

This block decides which power state a small microcontroller core is in and which clock it runs from. It owns one 8-bit control byte that software reads and writes while the core is running. That byte carries four things: a deep-standby enable, a 3-bit settling-time code, a run-from-subclock flag, and a 2-bit divider code for the medium-speed main clock.

A one-cycle sleep strobe moves the controller into a low-power state. The state it enters depends on the deep-standby enable, on whether the core is currently running from the main clock or from the subclock, and on a timer-running input. A wake event brings the core back. When the main oscillator was stopped, the wake passes through a settling state first. That state holds the CPU clock off for a power-of-two number of cycles chosen by the settling-time code.

The outputs are a registered one-hot mode vector, a CPU clock enable, a subclock select, a main-oscillator enable and the main-clock divide ratio.

Top module: `pmc_top`

## Requirements
- R1: After synchronous reset the control byte reads 0x07 and the mode is ACTIVE.
- R2: Bit 2 of the control byte always reads 1, and writes to it have no effect.
- R3: `div_ratio` equals 16, 32, 64 or 128 when control bits 1:0 hold 0, 1, 2 or 3.
- R4: The core switches between ACTIVE and SUBACTIVE as follows, and `cpu_clk_sub` is 1 only in SUBACTIVE.
  - In ACTIVE with control bit 3 set and no sleep strobe, the next mode is SUBACTIVE.
  - In SUBACTIVE with bit 3 clear and no sleep strobe, the next mode is ACTIVE.
- R5: The settling time is chosen by control bits 6:4.
  - Codes 0 to 3 give BASE_WAIT times 1, 2, 4 or 8 cycles.
  - Any code with bit 6 set gives BASE_WAIT times 16 cycles.
  - With the default BASE_WAIT of 8192, this is 8192 to 131072 cycles.
- R6: With control bit 7 clear, a sleep strobe moves ACTIVE to SLEEP and moves SUBACTIVE to SUBSLEEP on the next cycle.
- R7: With control bit 7 set, a sleep strobe moves SUBACTIVE to WATCH. It moves ACTIVE to WATCH when `timer_run` is 1, and to STANDBY when `timer_run` is 0.
- R8: A wake event in STANDBY enters SETTLE, which lasts exactly the R5 cycle count and then gives ACTIVE. During SETTLE, `cpu_clk_en` is 0 and `main_osc_en` is 1.
- R9: A wake event moves SLEEP to ACTIVE and moves SUBSLEEP to SUBACTIVE on the next cycle, with no settling.
- R10: A wake event in WATCH moves to SUBACTIVE when control bit 3 is set. When bit 3 is clear, it moves to SETTLE and then to ACTIVE, as in R8.
- R11: Writes to the control byte take effect only in ACTIVE or SUBACTIVE. In every other mode they are ignored.
- R12: `mode` is registered and one-hot. Bit 0 is ACTIVE, bit 1 SUBACTIVE, bit 2 SLEEP, bit 3 SUBSLEEP, bit 4 STANDBY, bit 5 WATCH and bit 6 SETTLE. `cpu_clk_en` is 1 only in ACTIVE and SUBACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Current control byte |
| sleep_req | input | 1 | One-cycle sleep strobe |
| wake_evt | input | 1 | Wake or interrupt event |
| timer_run | input | 1 | Timer keeps running, so ACTIVE sleeps into WATCH |
| mode | output | 7 | One-hot mode (R12 bit order) |
| cpu_clk_en | output | 1 | CPU clock enable |
| cpu_clk_sub | output | 1 | CPU runs from the subclock |
| main_osc_en | output | 1 | Main oscillator enable |
| div_ratio | output | 8 | Medium-speed main clock divide ratio |

## Verification
Every state bit is visible at a port, so most faults show up quickly.
- A wrong mode register or a wrong transition shows on `mode` and on the clock enables at the next clock edge.
- A wrong control-byte bit shows at once on `rdata` or `div_ratio`.
- A settling counter that is loaded or decremented wrongly is the slowest fault to appear. It shows as SETTLE ending early or late, so its length is measured for every settling code and also on a wake from WATCH.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int MODE_W  = 7;
    localparam int CTL_W   = 8;
    localparam int WSEL_W  = 3;
    localparam int DSEL_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_ACTIVE   = 7'b0000001,
        MODE_SUBACT   = 7'b0000010,
        MODE_SLEEP    = 7'b0000100,
        MODE_SUBSLEEP = 7'b0001000,
        MODE_STANDBY  = 7'b0010000,
        MODE_WATCH    = 7'b0100000,
        MODE_SETTLE   = 7'b1000000
    } pmc_mode_e;

    // control byte; field positions are software-visible
    typedef struct packed {
        logic              standby;
        logic [WSEL_W-1:0] wait_sel;
        logic              low_speed;
        logic              fixed_one;
        logic [DSEL_W-1:0] med_div;
    } sysctl_t;

    localparam logic [CTL_W-1:0] SYSCTL_RST   = 8'h07;
    localparam logic [CTL_W-1:0] SYSCTL_WMASK = 8'hFB;

    function automatic logic is_run_mode(pmc_mode_e m);
        return (m == MODE_ACTIVE) || (m == MODE_SUBACT);
    endfunction

    function automatic logic osc_needed(pmc_mode_e m);
        return (m == MODE_ACTIVE) || (m == MODE_SLEEP) || (m == MODE_SETTLE);
    endfunction

    function automatic logic [7:0] div_ratio_of(logic [DSEL_W-1:0] sel);
        return 8'd16 << sel;
    endfunction

endpackage

// File: rtl/pmc_sysctl_reg.sv
module pmc_sysctl_reg
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_allow,
    input  logic [CTL_W-1:0] wdata,
    output sysctl_t          q
);

    logic [CTL_W-1:0] bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits <= SYSCTL_RST;
        end else if (wr_en && wr_allow) begin
            // fixed bit forced high, write data masked off there
            bits <= (wdata & SYSCTL_WMASK) | ~SYSCTL_WMASK;
        end
    end

    assign q = sysctl_t'(bits);

endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
    parameter int BASE_WAIT = 8192,
    parameter int SEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);

    localparam int SAT_SHIFT = 1 << (SEL_W - 1);
    localparam int MAX_WAIT  = BASE_WAIT << SAT_SHIFT;
    localparam int CNT_W     = $clog2(MAX_WAIT + 1);

    logic [CNT_W-1:0] cnt;

    function automatic logic [CNT_W-1:0] wait_of(logic [SEL_W-1:0] s);
        if (s[SEL_W-1])
            return CNT_W'(MAX_WAIT);
        else
            return CNT_W'(BASE_WAIT) << s[SEL_W-2:0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= wait_of(sel);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // last settle cycle: the mode leaves SETTLE on the next edge
    assign done = (cnt == CNT_W'(1));

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sysctl_t   ctl,
    input  logic      sleep_req,
    input  logic      wake_evt,
    input  logic      timer_run,
    input  logic      settle_done,
    output pmc_mode_e mode,
    output logic      settle_load
);

    pmc_mode_e nxt;

    always_comb begin
        nxt = mode;
        case (mode)
            MODE_ACTIVE: begin
                if (sleep_req)
                    nxt = ctl.standby ? (timer_run ? MODE_WATCH : MODE_STANDBY)
                                      : MODE_SLEEP;
                else if (ctl.low_speed)
                    nxt = MODE_SUBACT;
            end
            MODE_SUBACT: begin
                if (sleep_req)
                    nxt = ctl.standby ? MODE_WATCH : MODE_SUBSLEEP;
                else if (!ctl.low_speed)
                    nxt = MODE_ACTIVE;
            end
            MODE_SLEEP:    if (wake_evt) nxt = MODE_ACTIVE;
            MODE_SUBSLEEP: if (wake_evt) nxt = MODE_SUBACT;
            MODE_STANDBY:  if (wake_evt) nxt = MODE_SETTLE;
            MODE_WATCH: begin
                if (wake_evt)
                    nxt = ctl.low_speed ? MODE_SUBACT : MODE_SETTLE;
            end
            MODE_SETTLE:   if (settle_done) nxt = MODE_ACTIVE;
            default:       nxt = MODE_ACTIVE;
        endcase
    end

    assign settle_load = (nxt == MODE_SETTLE) && (mode != MODE_SETTLE);

    always_ff @(posedge clk) begin
        if (rst) mode <= MODE_ACTIVE;
        else     mode <= nxt;
    end

endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter int BASE_WAIT = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTL_W-1:0]  wdata,
    output logic [CTL_W-1:0]  rdata,
    input  logic              sleep_req,
    input  logic              wake_evt,
    input  logic              timer_run,
    output logic [MODE_W-1:0] mode,
    output logic              cpu_clk_en,
    output logic              cpu_clk_sub,
    output logic              main_osc_en,
    output logic [7:0]        div_ratio
);

    sysctl_t   ctl;
    pmc_mode_e cur;
    logic      settle_load;
    logic      settle_done;

    pmc_sysctl_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_allow (is_run_mode(cur)),
        .wdata    (wdata),
        .q        (ctl)
    );

    pmc_mode_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .sleep_req   (sleep_req),
        .wake_evt    (wake_evt),
        .timer_run   (timer_run),
        .settle_done (settle_done),
        .mode        (cur),
        .settle_load (settle_load)
    );

    pmc_settle_timer #(
        .BASE_WAIT (BASE_WAIT),
        .SEL_W     (WSEL_W)
    ) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (settle_load),
        .sel  (ctl.wait_sel),
        .done (settle_done)
    );

    assign rdata       = ctl;
    assign mode        = cur;
    assign cpu_clk_en  = is_run_mode(cur);
    assign cpu_clk_sub = (cur == MODE_SUBACT);
    assign main_osc_en = osc_needed(cur);
    assign div_ratio   = div_ratio_of(ctl.med_div);

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
    import pmc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [CTL_W-1:0]  rdata,
    input logic              sleep_req,
    input logic              wake_evt,
    input logic              timer_run,
    input logic [MODE_W-1:0] mode,
    input logic              cpu_clk_en,
    input logic              main_osc_en
);

    logic in_run;
    assign in_run = (mode == MODE_ACTIVE) || (mode == MODE_SUBACT);

    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(mode) == 1); // R12

    AST_FIXED_BIT_SET: assert property (@(posedge clk) disable iff (rst)
        rdata[2]); // R2

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_ACTIVE && sleep_req && !rdata[7]) |=> (mode == MODE_SLEEP)); // R6

    AST_SUBSLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SUBACT && sleep_req && !rdata[7]) |=> (mode == MODE_SUBSLEEP)); // R6

    AST_WATCH_FROM_SUB: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SUBACT && sleep_req && rdata[7]) |=> (mode == MODE_WATCH)); // R7

    AST_STANDBY_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_ACTIVE && sleep_req && rdata[7] && !timer_run)
        |=> (mode == MODE_STANDBY)); // R7

    AST_SETTLE_GATED: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SETTLE) |-> (!cpu_clk_en && main_osc_en)); // R8

    AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SLEEP && wake_evt) |=> (mode == MODE_ACTIVE)); // R9

    AST_LP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!in_run && wr_en) |=> $stable(rdata)); // R11

endmodule

bind pmc_top pmc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rdata       (rdata),
    .sleep_req   (sleep_req),
    .wake_evt    (wake_evt),
    .timer_run   (timer_run),
    .mode        (mode),
    .cpu_clk_en  (cpu_clk_en),
    .main_osc_en (main_osc_en)
);

// File: tb/pmc_top_tb.sv
`timescale 1ns/1ps
module pmc_top_tb;

    localparam int BASE = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       sleep_req = 1'b0;
    logic       wake_evt = 1'b0;
    logic       timer_run = 1'b0;
    logic [7:0] rdata;
    logic [6:0] mode;
    logic       cpu_clk_en, cpu_clk_sub, main_osc_en;
    logic [7:0] div_ratio;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pmc_top #(.BASE_WAIT(BASE)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .sleep_req(sleep_req), .wake_evt(wake_evt), .timer_run(timer_run),
        .mode(mode), .cpu_clk_en(cpu_clk_en), .cpu_clk_sub(cpu_clk_sub),
        .main_osc_en(main_osc_en), .div_ratio(div_ratio)
    );

    // reference model: mode codes 0 ACTIVE,1 SUBACT,2 SLEEP,3 SUBSLEEP,
    // 4 STANDBY,5 WATCH,6 SETTLE
    logic [7:0] m_reg;
    int         m_mode;
    int         m_cnt;
    int         nm;
    logic [7:0] nr;

    function automatic int wait_len(logic [2:0] s);
        if (s[2]) return BASE * 16;
        return BASE << s[1:0];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_reg = 8'h07; m_mode = 0; m_cnt = 0;
        end else begin
            nm = m_mode;
            nr = m_reg;
            if (m_mode <= 1 && wr_en) nr = (wdata & 8'hFB) | 8'h04;
            case (m_mode)
                0: if (sleep_req) nm = m_reg[7] ? (timer_run ? 5 : 4) : 2;
                   else if (m_reg[3]) nm = 1;
                1: if (sleep_req) nm = m_reg[7] ? 5 : 3;
                   else if (!m_reg[3]) nm = 0;
                2: if (wake_evt) nm = 0;
                3: if (wake_evt) nm = 1;
                4: if (wake_evt) begin nm = 6; m_cnt = wait_len(m_reg[6:4]); end
                5: if (wake_evt) begin
                       if (m_reg[3]) nm = 1;
                       else begin nm = 6; m_cnt = wait_len(m_reg[6:4]); end
                   end
                default: if (m_cnt == 1) nm = 0; else m_cnt = m_cnt - 1;
            endcase
            m_mode = nm;
            m_reg = nr;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R12 mode", int'(mode), 1 << m_mode);
            chk("R12 cpu_clk_en", int'(cpu_clk_en), int'(m_mode <= 1));
            chk("R4 cpu_clk_sub", int'(cpu_clk_sub), int'(m_mode == 1));
            chk("R8 main_osc_en", int'(main_osc_en),
                int'(m_mode == 0 || m_mode == 2 || m_mode == 6));
            chk("R2 rdata", int'(rdata), int'(m_reg));
            chk("R3 div_ratio", int'(div_ratio), 16 << m_reg[1:0]);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(logic [7:0] v);
        wr_en = 1'b1; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
    endtask

    task automatic measure_settle(string tag, int exp);
        int n = 0;
        while (mode[6] && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(tag, n, exp);
        chk("R8 active after settle", int'(mode), 1);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk("R1 reset rdata", int'(rdata), 8'h07);
        chk("R1 reset mode", int'(mode), 1);

        write_reg(8'h00);
        chk("R2 fixed bit", int'(rdata), 8'h04);
        for (int d = 0; d < 4; d++) begin
            write_reg(8'(d));
            chk("R3 divider", int'(div_ratio), 16 << d);
        end

        write_reg(8'h08);
        cyc(1);
        chk("R4 to subactive", int'(mode), 2);
        chk("R4 subclock", int'(cpu_clk_sub), 1);
        write_reg(8'h00);
        cyc(1);
        chk("R4 back to active", int'(mode), 1);

        pulse_sleep();
        chk("R6 sleep", int'(mode), 4);
        write_reg(8'hF3);
        chk("R11 write ignored", int'(rdata), 8'h04);
        pulse_wake();
        chk("R9 sleep wake", int'(mode), 1);

        write_reg(8'h08);
        cyc(1);
        pulse_sleep();
        chk("R6 subsleep", int'(mode), 8);
        pulse_wake();
        chk("R9 subsleep wake", int'(mode), 2);

        write_reg(8'h88);
        pulse_sleep();
        chk("R7 watch from subactive", int'(mode), 32);
        pulse_wake();
        chk("R10 watch wake subclock", int'(mode), 2);

        write_reg(8'h80);
        cyc(1);
        chk("R4 active again", int'(mode), 1);
        timer_run = 1'b1;
        pulse_sleep();
        chk("R7 watch from active", int'(mode), 32);
        timer_run = 1'b0;
        pulse_wake();
        chk("R10 watch wake settle", int'(mode), 64);
        measure_settle("R10 settle length", BASE);

        for (int s = 0; s < 8; s++) begin
            write_reg(8'h80 | 8'(s << 4));
            pulse_sleep();
            chk("R7 standby", int'(mode), 16);
            pulse_wake();
            chk("R8 cpu clock gated", int'(cpu_clk_en), 0);
            measure_settle("R5 settle length", (s >= 4) ? BASE * 16 : (BASE << s));
        end

        cyc(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog act=hung exp=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule